// File: doc/BRIEF.md
# Acknowledged Transmit Retry Controller

This block sequences the transmission of queued packets over a half-duplex radio link that confirms delivery. A packet is released only after a start level has been held long enough and the radio has settled. After the packet goes out, the controller listens for a confirmation. A confirmation removes the packet from the queue and raises a delivered flag. If the listen window closes with no confirmation, the packet is sent again, up to a programmable number of retries. When the retries are used up, the controller keeps the packet, raises a give-up flag that blocks any further sending, and counts the loss.

Both flags drive a shared active-low interrupt. Software clears each flag by pulsing its own clear input. A packet marked as needing no confirmation counts as delivered as soon as its air time ends. The mode output shows what the controller is doing. Idle with the start level low is 0. Idle with the start level high is 1. Settling is 2. Sending is 3. Listening is 4. All timings are parameters counted in clock cycles.

Top module: `arq_tx_ctrl`

## Requirements
- R1: After reset, mode_o is 0, both flags are 0, irq_n_o is 1, loss_cnt_o is 0, and tx_start_o and fifo_pop_o are 0.
- R2: Leaving mode 0 requires start_i to have been high on CE_MIN_CYC consecutive clock edges. A shorter high pulse starts nothing and leaves mode_o at 0.
- R3: Every transmission attempt spends exactly SETTLE_CYC cycles in mode 2 and then AIR_CYC cycles in mode 3. tx_start_o pulses for one cycle on entry to mode 3.
- R4: An ack_i pulse seen in mode 4 gives exactly one fifo_pop_o pulse and sets sent_flag_o. The packet is not sent again.
- R5: A listen window with no ack lasts (retry_delay_i+1)×ACK_UNIT_CYC cycles in mode 4. After it, the packet is sent again while fewer than retry_limit_i retries have been made. A packet is therefore sent retry_limit_i+1 times at most. A limit of 0 means a single attempt.
- R6: When the retries are exhausted, maxrt_flag_o is set, no fifo_pop_o is given, and loss_cnt_o rises by one.
- R7: While maxrt_flag_o is 1, no new transmission starts, even with start_i high and the queue not empty.
- R8: loss_cnt_o is 4 bits wide and holds at 15 once it gets there.
- R9: irq_n_o is 0 exactly when at least one flag is 1. A one-cycle pulse on clr_sent_i or clr_maxrt_i clears only its own flag.
- R10: A packet whose no_ack_i is 1 at the start of its send is popped and marked as sent right after mode 3. It never enters mode 4.
- R11: After a packet completes, the next mode depends on the inputs. With start_i high and the queue empty, it goes to mode 1. With start_i high and more data, it sends the next packet. With start_i low, it goes back to mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start/enable level |
| fifo_nonempty_i | input | 1 | Transmit queue holds at least one packet |
| ack_i | input | 1 | One-cycle pulse: confirmation received |
| no_ack_i | input | 1 | Current packet needs no confirmation |
| retry_delay_i | input | CFG_W | Listen window = (value+1)×ACK_UNIT_CYC cycles |
| retry_limit_i | input | CFG_W | Maximum number of retransmissions |
| clr_sent_i | input | 1 | Clear the delivered flag |
| clr_maxrt_i | input | 1 | Clear the give-up flag |
| tx_start_o | output | 1 | One-cycle trigger to the radio to send |
| fifo_pop_o | output | 1 | One-cycle pop of the delivered packet |
| sent_flag_o | output | 1 | Delivered flag |
| maxrt_flag_o | output | 1 | Give-up flag |
| irq_n_o | output | 1 | Active-low interrupt |
| loss_cnt_o | output | LOSS_W | Saturating count of given-up packets |
| mode_o | output | 3 | Current mode, encoded as in the description |

## Verification
Every output is registered. A mode change, a pop, a flag change and the interrupt all show up one cycle after the clock edge that samples their cause. A new start_i level takes one more cycle, because the hold counter sits in front of the mode logic. The bench drives inputs on falling edges. It samples outputs once per cycle, a quarter period after each rising edge. It counts cycles spent in each mode and the start and pop pulses. Phase lengths are checked as exact cycle totals against SETTLE_CYC, AIR_CYC and the listen window, so an extra or missing cycle in any phase is reported.

// File: rtl/arq_pkg.sv
package arq_pkg;
  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_HOLD   = 3'd1,
    M_SETTLE = 3'd2,
    M_SEND   = 3'd3,
    M_LISTEN = 3'd4
  } arq_mode_e;
endpackage

// File: rtl/arq_hold_qual.sv
// Qualifies the start level: true once it has been high on MIN_CYC edges in a row.
module arq_hold_qual #(
  parameter int MIN_CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic held_o
);
  localparam int W = $clog2(MIN_CYC + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !level_i) cnt_q <= '0;
    else if (cnt_q != W'(MIN_CYC)) cnt_q <= cnt_q + W'(1);
  end

  assign held_o = (cnt_q == W'(MIN_CYC));
endmodule

// File: rtl/arq_phase_timer.sv
// Counts cycles spent in the current phase; restarts at zero on a phase change.
module arq_phase_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart_i,
  output logic [TW-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst || restart_i) count_o <= '0;
    else if (count_o != {TW{1'b1}}) count_o <= count_o + TW'(1);
  end
endmodule

// File: rtl/arq_sat_cnt.sv
// Saturating event counter.
module arq_sat_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst) count_o <= '0;
    else if (inc_i && count_o != {W{1'b1}}) count_o <= count_o + W'(1);
  end
endmodule

// File: rtl/arq_tx_ctrl.sv
module arq_tx_ctrl #(
  parameter int CE_MIN_CYC   = 500,
  parameter int SETTLE_CYC   = 6500,
  parameter int AIR_CYC      = 200,
  parameter int ACK_UNIT_CYC = 12500,
  parameter int CFG_W        = 4,
  parameter int LOSS_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              fifo_nonempty_i,
  input  logic              ack_i,
  input  logic              no_ack_i,
  input  logic [CFG_W-1:0]  retry_delay_i,
  input  logic [CFG_W-1:0]  retry_limit_i,
  input  logic              clr_sent_i,
  input  logic              clr_maxrt_i,
  output logic              tx_start_o,
  output logic              fifo_pop_o,
  output logic              sent_flag_o,
  output logic              maxrt_flag_o,
  output logic              irq_n_o,
  output logic [LOSS_W-1:0] loss_cnt_o,
  output logic [2:0]        mode_o
);
  import arq_pkg::*;

  localparam int TW = $clog2((1 << CFG_W) * ACK_UNIT_CYC + SETTLE_CYC + AIR_CYC + 2);

  arq_mode_e        st_q, st_d;
  logic [CFG_W-1:0] retry_q, retry_d;
  logic [TW-1:0]    tcnt;
  logic [TW-1:0]    wait_lim;
  logic             held, go, ok_evt, loss_evt, na_q;
  logic             sent_d, maxrt_d;
  arq_mode_e        post;

  arq_hold_qual #(.MIN_CYC(CE_MIN_CYC)) u_hold (
    .clk(clk), .rst(rst), .level_i(start_i), .held_o(held));

  arq_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .restart_i(st_d != st_q), .count_o(tcnt));

  arq_sat_cnt #(.W(LOSS_W)) u_loss (
    .clk(clk), .rst(rst), .inc_i(loss_evt), .count_o(loss_cnt_o));

  assign wait_lim = (TW'(retry_delay_i) + TW'(1)) * TW'(ACK_UNIT_CYC);
  assign go       = held && fifo_nonempty_i && !maxrt_flag_o && !fifo_pop_o;
  assign post     = held ? M_HOLD : M_IDLE;

  always_comb begin
    st_d     = st_q;
    retry_d  = retry_q;
    ok_evt   = 1'b0;
    loss_evt = 1'b0;
    unique case (st_q)
      M_IDLE: if (held) begin
        st_d    = go ? M_SETTLE : M_HOLD;
        retry_d = '0;
      end
      M_HOLD: if (!held) st_d = M_IDLE;
              else if (go) begin
                st_d    = M_SETTLE;
                retry_d = '0;
              end
      M_SETTLE: if (tcnt == TW'(SETTLE_CYC - 1)) st_d = M_SEND;
      M_SEND: if (tcnt == TW'(AIR_CYC - 1)) begin
        if (na_q) begin
          ok_evt = 1'b1;
          st_d   = post;
        end else begin
          st_d = M_LISTEN;
        end
      end
      M_LISTEN: if (ack_i) begin
        ok_evt = 1'b1;
        st_d   = post;
      end else if (tcnt == wait_lim - TW'(1)) begin
        if (retry_q < retry_limit_i) begin
          retry_d = retry_q + CFG_W'(1);
          st_d    = M_SETTLE;
        end else begin
          loss_evt = 1'b1;
          st_d     = post;
        end
      end
      default: st_d = M_IDLE;
    endcase
  end

  // A new event sets its flag even if a clear arrives in the same cycle.
  assign sent_d  = ok_evt   | (sent_flag_o  & ~clr_sent_i);
  assign maxrt_d = loss_evt | (maxrt_flag_o & ~clr_maxrt_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= M_IDLE;
      retry_q      <= '0;
      na_q         <= 1'b0;
      tx_start_o   <= 1'b0;
      fifo_pop_o   <= 1'b0;
      sent_flag_o  <= 1'b0;
      maxrt_flag_o <= 1'b0;
      irq_n_o      <= 1'b1;
    end else begin
      st_q         <= st_d;
      retry_q      <= retry_d;
      if (st_q == M_SETTLE && st_d == M_SEND) na_q <= no_ack_i;
      tx_start_o   <= (st_q == M_SETTLE) && (st_d == M_SEND);
      fifo_pop_o   <= ok_evt;
      sent_flag_o  <= sent_d;
      maxrt_flag_o <= maxrt_d;
      irq_n_o      <= ~(sent_d | maxrt_d);
    end
  end

  assign mode_o = st_q;
endmodule

// File: rtl/arq_tx_ctrl_chk.sv
module arq_tx_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_start_o,
  input logic       fifo_pop_o,
  input logic       sent_flag_o,
  input logic       maxrt_flag_o,
  input logic       irq_n_o,
  input logic [3:0] loss_cnt_o,
  input logic [2:0] mode_o
);
  assert_start_after_settle_R3: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |-> (mode_o == 3'd3 && $past(mode_o) == 3'd2));

  assert_pop_after_send_R4: assert property (@(posedge clk) disable iff (rst)
    fifo_pop_o |-> ($past(mode_o) == 3'd4 || $past(mode_o) == 3'd3));

  assert_giveup_no_pop_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(maxrt_flag_o) |-> !fifo_pop_o);

  assert_blocked_start_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd2 && ($past(mode_o) == 3'd0 || $past(mode_o) == 3'd1)) |-> !$past(maxrt_flag_o));

  assert_loss_step_R8: assert property (@(posedge clk) disable iff (rst)
    (loss_cnt_o != $past(loss_cnt_o)) |-> (loss_cnt_o == $past(loss_cnt_o) + 4'd1));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == !(sent_flag_o || maxrt_flag_o));
endmodule

bind arq_tx_ctrl arq_tx_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .tx_start_o(tx_start_o), .fifo_pop_o(fifo_pop_o),
  .sent_flag_o(sent_flag_o), .maxrt_flag_o(maxrt_flag_o), .irq_n_o(irq_n_o),
  .loss_cnt_o(loss_cnt_o[3:0]), .mode_o(mode_o));

// File: tb/arq_tx_ctrl_tb.sv
`timescale 1ns/1ps
module arq_tx_ctrl_tb;
  localparam int CE_MIN = 4, SETTLE = 5, AIR = 3, UNIT = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, ack_i = 0, no_ack_i = 0, clr_sent_i = 0, clr_maxrt_i = 0;
  logic [3:0] retry_delay_i = 0, retry_limit_i = 0;
  logic tx_start_o, fifo_pop_o, sent_flag_o, maxrt_flag_o, irq_n_o;
  logic [3:0] loss_cnt_o;
  logic [2:0] mode_o;
  int pkts = 0;
  int n_chk = 0, n_fail = 0;
  int c_settle = 0, c_send = 0, c_listen = 0, c_start = 0, c_pop = 0;

  always #10 clk = ~clk;

  arq_tx_ctrl #(.CE_MIN_CYC(CE_MIN), .SETTLE_CYC(SETTLE), .AIR_CYC(AIR),
                .ACK_UNIT_CYC(UNIT), .CFG_W(4), .LOSS_W(4)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .fifo_nonempty_i(pkts != 0),
    .ack_i(ack_i), .no_ack_i(no_ack_i), .retry_delay_i(retry_delay_i),
    .retry_limit_i(retry_limit_i), .clr_sent_i(clr_sent_i), .clr_maxrt_i(clr_maxrt_i),
    .tx_start_o(tx_start_o), .fifo_pop_o(fifo_pop_o), .sent_flag_o(sent_flag_o),
    .maxrt_flag_o(maxrt_flag_o), .irq_n_o(irq_n_o), .loss_cnt_o(loss_cnt_o), .mode_o(mode_o));

  // Queue model and per-cycle monitor, sampled 5 ns after each rising edge.
  always @(posedge clk) begin
    #5;
    if (fifo_pop_o && pkts > 0) pkts = pkts - 1;
    if (mode_o == 3'd2) c_settle++;
    if (mode_o == 3'd3) c_send++;
    if (mode_o == 3'd4) c_listen++;
    if (tx_start_o) c_start++;
    if (fifo_pop_o) c_pop++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic zero();
    c_settle = 0; c_send = 0; c_listen = 0; c_start = 0; c_pop = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_mode(input int m, input string req);
    int k = 0;
    while (mode_o != 3'(m) && k < 400) begin @(negedge clk); k++; end
    chk({req, " reach mode"}, mode_o, m);
  endtask

  task automatic wait_maxrt(input string req);
    int k = 0;
    while (!maxrt_flag_o && k < 400) begin @(negedge clk); k++; end
    chk({req, " give-up flag"}, maxrt_flag_o, 1);
  endtask

  task automatic pulse_clr(input bit s, input bit m);
    clr_sent_i = s; clr_maxrt_i = m; @(negedge clk);
    clr_sent_i = 0; clr_maxrt_i = 0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode_o, 0);
    chk("R1 sent", sent_flag_o, 0);
    chk("R1 maxrt", maxrt_flag_o, 0);
    chk("R1 irq_n", irq_n_o, 1);
    chk("R1 loss", loss_cnt_o, 0);
    chk("R1 start/pop", {tx_start_o, fifo_pop_o}, 0);
  endtask

  task automatic t_short_start();
    zero(); pkts = 1;
    start_i = 1; cyc(CE_MIN - 1); start_i = 0;
    cyc(20);
    chk("R2 no settle", c_settle, 0);
    chk("R2 mode idle", mode_o, 0);
  endtask

  task automatic t_ack();
    zero(); retry_limit_i = 3; retry_delay_i = 1;
    start_i = 1;
    wait_mode(4, "R4");
    cyc(2); ack_i = 1; @(negedge clk); ack_i = 0;
    wait_mode(1, "R11");
    cyc(2);
    chk("R3 settle cycles", c_settle, SETTLE);
    chk("R3 send cycles", c_send, AIR);
    chk("R3 start pulses", c_start, 1);
    chk("R4 pops", c_pop, 1);
    chk("R4 sent flag", sent_flag_o, 1);
    chk("R9 irq asserted", irq_n_o, 0);
    chk("R11 hold when empty", mode_o, 1);
    pulse_clr(0, 1);
    chk("R9 other clear keeps sent", sent_flag_o, 1);
    pulse_clr(1, 0);
    chk("R9 sent cleared", sent_flag_o, 0);
    chk("R9 irq released", irq_n_o, 1);
    start_i = 0; cyc(3);
    chk("R11 idle on low start", mode_o, 0);
  endtask

  task automatic t_noack();
    zero(); no_ack_i = 1; pkts = 1; start_i = 1;
    cyc(CE_MIN + SETTLE + AIR + 4);
    chk("R10 no listen", c_listen, 0);
    chk("R10 popped", c_pop, 1);
    chk("R10 sent", sent_flag_o, 1);
    pulse_clr(1, 0);
    zero(); pkts = 2;
    cyc(2 * (SETTLE + AIR + 3) + 4);
    chk("R11 back-to-back starts", c_start, 2);
    chk("R11 queue drained", pkts, 0);
    chk("R11 hold after drain", mode_o, 1);
    pulse_clr(1, 0);
    start_i = 0; no_ack_i = 0; cyc(3);
  endtask

  task automatic t_giveup();
    zero(); retry_limit_i = 2; retry_delay_i = 1; pkts = 1; start_i = 1;
    wait_maxrt("R6");
    cyc(2);
    chk("R5 attempts", c_start, 3);
    chk("R5 listen cycles", c_listen, 3 * 2 * UNIT);
    chk("R6 no pop", c_pop, 0);
    chk("R6 packet kept", pkts, 1);
    chk("R6 loss", loss_cnt_o, 1);
    cyc(40);
    chk("R7 blocked", c_start, 3);
    zero(); pulse_clr(0, 1);
    wait_mode(4, "R7");
    cyc(1); ack_i = 1; @(negedge clk); ack_i = 0;
    cyc(3);
    chk("R7 resumes after clear", c_start, 1);
    chk("R4 pop after resume", pkts, 0);
    pulse_clr(1, 0);
    start_i = 0; cyc(3);
  endtask

  task automatic t_limit0_sat();
    zero(); retry_limit_i = 0; retry_delay_i = 0; pkts = 1; start_i = 1;
    wait_maxrt("R5");
    cyc(2);
    chk("R5 single attempt", c_start, 1);
    chk("R5 window one unit", c_listen, UNIT);
    chk("R8 loss two", loss_cnt_o, 2);
    for (int i = 0; i < 15; i++) begin
      pulse_clr(0, 1);
      wait_maxrt("R8");
    end
    chk("R8 saturated", loss_cnt_o, 15);
    start_i = 0;
  endtask

  initial begin
    cyc(3); @(negedge clk); rst = 0; @(negedge clk);
    t_reset();
    t_short_start();
    t_ack();
    t_noack();
    t_giveup();
    t_limit0_sat();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule